// File: doc/BRIEF.md
# PCIe Root Complex MSI Capture Controller

This block receives message-signalled interrupts for a single root complex. It watches the stream of inbound memory requests from endpoints. A full 32-bit write into a private four-byte window is taken as an interrupt message. The written data is the vector number, from 0 to 63. That vector sets one bit in one of two 32-bit pending words and raises the root complex interrupt line. Because each root complex has its own window, a message aimed at one complex never reaches the pending state of another, even when every complex uses the same window address.

Inbound requests that fall inside a configurable DRAM range go out on a pass-through port unchanged, one cycle later. Requests that match neither the window nor the range are dropped and raise a one-cycle error pulse.

Software uses a small register port. Through it, software reads and writes two words of enable storage and reads the two pending words. It clears pending bits by writing ones. Two values are special. A write of zero does nothing. A write of all ones clears the word but leaves the interrupt line as it is, because it is an initialisation and not a serviced interrupt. Any other clear that leaves both pending words empty lowers the interrupt line.

Top module: `msi_capture_top`

## Requirements
- R1: An inbound full write to the window whose data is 64 or greater pulses `bad_vec` high for one cycle, in the cycle after the write. It changes no pending bit and does not raise `irq`.
- R2: A write of vector v (0 to 63) sets bit v of pending word 0 (offset 0xE8) when v < 32. When v >= 32 it sets bit v-32 of pending word 1 (offset 0xEC). The bit is visible from the cycle after the write.
- R3: Every captured vector drives `irq` high from the cycle after the write. `irq` is never low while any pending bit is set.
- R4: The register offsets are as follows. Enable word 0 is at 0xE0 and enable word 1 is at 0xE4. Pending word 0 is at 0xE8 and pending word 1 is at 0xEC. The enable words are plain read/write storage and do not gate capture. Reads of any other offset return zero, and writes to any other offset change nothing. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R5: A register write of 0x00000000 to a pending word changes neither the pending words nor `irq`.
- R6: A nonzero write to a pending word clears each pending bit whose data bit is 1. When a capture sets a bit in the same cycle as that bit is cleared, the bit stays set.
- R7: A write of 0xFFFFFFFF to a pending word clears that word and leaves `irq` unchanged.
- R8: After any other nonzero clear, `irq` goes low if both pending words are zero. If either word still holds a bit, `irq` stays high.
- R9: The window is the four bytes at `MSI_BASE` (default 0x1E77005C). Only writes with `in_be` = 4'hF are captured, with the data taken little-endian as a 32-bit value. A window write with any other byte enable is dropped and pulses `acc_err`. A window read pulses `win_rvalid` with `win_rdata` = 0 and has no side effect.
- R10: An inbound request with an address in [`DRAM_BASE`, `DRAM_BASE`+`DRAM_SIZE`) appears on the `dram_*` port one cycle later. Its write flag, address, data and byte enables are unchanged, and it never touches the pending words or `irq`.
- R11: An inbound request that hits neither the window nor the DRAM range is dropped. It pulses `acc_err` for one cycle in the cycle after the request.
- R12: After synchronous reset, all enable and pending words read zero and `irq`, `bad_vec`, `acc_err`, `win_rvalid` and `dram_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound request valid |
| in_write | input | 1 | Inbound request is a write |
| in_addr | input | AW | Inbound byte address |
| in_data | input | 32 | Inbound write data |
| in_be | input | 4 | Inbound byte enables |
| dram_valid | output | 1 | Forwarded request valid |
| dram_write | output | 1 | Forwarded write flag |
| dram_addr | output | AW | Forwarded address |
| dram_wdata | output | 32 | Forwarded write data |
| dram_be | output | 4 | Forwarded byte enables |
| win_rvalid | output | 1 | Window read acknowledge |
| win_rdata | output | 32 | Window read data, always zero |
| acc_err | output | 1 | Dropped request pulse |
| bad_vec | output | 1 | Out-of-range vector pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Root complex interrupt |

## Verification
Interrupt capture and software clearing can fall in the same clock cycle. Both can also target the same bit, and they meet in the pending-word update and in the interrupt line. The bench first leaves two bits pending. In one cycle it then drives a window write of one of those vectors together with a register clear of both bits. It judges the result by reading the pending word back, which must show the captured bit still set, and by seeing that `irq` stays high. A later partial clear must then lower `irq`.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;
  localparam int LANE_LG = 5;
  localparam logic [BE_W-1:0] FULL_BE = '1;
endpackage

// File: rtl/msi_inb_decode.sv
module msi_inb_decode
  import msi_cap_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          NVEC      = 64,
  parameter logic [AW-1:0] MSI_BASE  = 32'h1E77_005C,
  parameter logic [AW-1:0] DRAM_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] DRAM_SIZE = 32'h1000_0000,
  localparam int         VW        = $clog2(NVEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [AW-1:0]     in_addr,
  input  logic [WORD_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic              cap_valid,
  output logic [VW-1:0]     cap_vec,
  output logic              dram_valid,
  output logic              dram_write,
  output logic [AW-1:0]     dram_addr,
  output logic [WORD_W-1:0] dram_wdata,
  output logic [BE_W-1:0]   dram_be,
  output logic              win_rvalid,
  output logic              acc_err,
  output logic              bad_vec
);
  logic          win_hit, dram_hit, full_wr, vec_ok;
  logic [AW:0]   dram_off;

  assign win_hit  = (in_addr[AW-1:2] == MSI_BASE[AW-1:2]);
  assign dram_off = {1'b0, in_addr} - {1'b0, DRAM_BASE};
  assign dram_hit = !win_hit && (in_addr >= DRAM_BASE) && (dram_off < {1'b0, DRAM_SIZE});
  assign full_wr  = in_valid && in_write && win_hit && (in_be == FULL_BE);
  assign vec_ok   = (in_data < WORD_W'(NVEC));

  assign cap_valid = full_wr && vec_ok;
  assign cap_vec   = in_data[VW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_valid <= 1'b0;
      dram_write <= 1'b0;
      dram_addr  <= '0;
      dram_wdata <= '0;
      dram_be    <= '0;
      win_rvalid <= 1'b0;
      acc_err    <= 1'b0;
      bad_vec    <= 1'b0;
    end else begin
      dram_valid <= in_valid && dram_hit;
      if (in_valid && dram_hit) begin
        dram_write <= in_write;
        dram_addr  <= in_addr;
        dram_wdata <= in_data;
        dram_be    <= in_be;
      end
      win_rvalid <= in_valid && !in_write && win_hit;
      acc_err    <= in_valid && ((!win_hit && !dram_hit) ||
                                 (win_hit && in_write && in_be != FULL_BE));
      bad_vec    <= full_wr && !vec_ok;
    end
  end
endmodule

// File: rtl/msi_vec_status.sv
module msi_vec_status
  import msi_cap_pkg::*;
#(
  parameter int  NVEC   = 64,
  localparam int VW     = $clog2(NVEC),
  localparam int NWORDS = NVEC / WORD_W,
  localparam int SW     = VW - LANE_LG
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_valid,
  input  logic [VW-1:0]            cap_vec,
  input  logic [NWORDS-1:0]        sts_we,
  input  logic [WORD_W-1:0]        sts_wdata,
  output logic [NWORDS*WORD_W-1:0] sts_flat,
  output logic                     irq
);
  logic [NWORDS*WORD_W-1:0] nxt_flat;
  logic                     clr_req, init_req;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [SW-1:0] WID = SW'(w);
    logic [WORD_W-1:0] set_m, clr_m;
    assign set_m = (cap_valid && cap_vec[VW-1:LANE_LG] == WID) ?
                   (WORD_W'(1) << cap_vec[LANE_LG-1:0]) : '0;
    assign clr_m = sts_we[w] ? sts_wdata : '0;
    assign nxt_flat[w*WORD_W +: WORD_W] = (sts_flat[w*WORD_W +: WORD_W] & ~clr_m) | set_m;
    always_ff @(posedge clk) begin
      if (rst) sts_flat[w*WORD_W +: WORD_W] <= '0;
      else     sts_flat[w*WORD_W +: WORD_W] <= nxt_flat[w*WORD_W +: WORD_W];
    end
  end

  assign clr_req  = (|sts_we) && (sts_wdata != '0);
  assign init_req = (sts_wdata == '1);

  always_ff @(posedge clk) begin
    if (rst)                                          irq <= 1'b0;
    else if (cap_valid)                               irq <= 1'b1;
    else if (clr_req && !init_req && nxt_flat == '0)  irq <= 1'b0;
  end
endmodule

// File: rtl/msi_csr.sv
module msi_csr
  import msi_cap_pkg::*;
#(
  parameter int  RAW     = 8,
  parameter int  NVEC    = 64,
  parameter logic [RAW-1:0] EN_BASE = 8'hE0,
  localparam int NWORDS  = NVEC / WORD_W,
  localparam logic [RAW-1:0] STS_BASE = EN_BASE + RAW'(4 * NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [RAW-1:0]           reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  input  logic [NWORDS*WORD_W-1:0] sts_flat,
  output logic [NWORDS-1:0]        sts_we,
  output logic [WORD_W-1:0]        reg_rdata
);
  logic [NWORDS*WORD_W-1:0] en_flat;
  logic [NWORDS-1:0]        en_sel, st_sel;
  logic [WORD_W-1:0]        rd_mux;

  for (genvar w = 0; w < NWORDS; w++) begin : g_reg
    assign en_sel[w] = (reg_addr == EN_BASE  + RAW'(4 * w));
    assign st_sel[w] = (reg_addr == STS_BASE + RAW'(4 * w));
    assign sts_we[w] = reg_wr && st_sel[w];
    always_ff @(posedge clk) begin
      if (rst)                     en_flat[w*WORD_W +: WORD_W] <= '0;
      else if (reg_wr && en_sel[w]) en_flat[w*WORD_W +: WORD_W] <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (en_sel[w]) rd_mux = en_flat[w*WORD_W +: WORD_W];
      if (st_sel[w]) rd_mux = sts_flat[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top
  import msi_cap_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            RAW       = 8,
  parameter int            NVEC      = 64,
  parameter logic [AW-1:0] MSI_BASE  = 32'h1E77_005C,
  parameter logic [AW-1:0] DRAM_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] DRAM_SIZE = 32'h1000_0000,
  localparam int           VW        = $clog2(NVEC),
  localparam int           NWORDS    = NVEC / WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [AW-1:0]     in_addr,
  input  logic [31:0]       in_data,
  input  logic [3:0]        in_be,
  output logic              dram_valid,
  output logic              dram_write,
  output logic [AW-1:0]     dram_addr,
  output logic [31:0]       dram_wdata,
  output logic [3:0]        dram_be,
  output logic              win_rvalid,
  output logic [31:0]       win_rdata,
  output logic              acc_err,
  output logic              bad_vec,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                     cap_valid;
  logic [VW-1:0]            cap_vec;
  logic [NWORDS-1:0]        sts_we;
  logic [NWORDS*WORD_W-1:0] sts_flat;

  assign win_rdata = '0;

  msi_inb_decode #(.AW(AW), .NVEC(NVEC), .MSI_BASE(MSI_BASE),
                   .DRAM_BASE(DRAM_BASE), .DRAM_SIZE(DRAM_SIZE)) u_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_write(in_write),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
    .cap_valid(cap_valid), .cap_vec(cap_vec),
    .dram_valid(dram_valid), .dram_write(dram_write), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_be(dram_be),
    .win_rvalid(win_rvalid), .acc_err(acc_err), .bad_vec(bad_vec));

  msi_vec_status #(.NVEC(NVEC)) u_sts (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_vec(cap_vec),
    .sts_we(sts_we), .sts_wdata(reg_wdata), .sts_flat(sts_flat), .irq(irq));

  msi_csr #(.RAW(RAW), .NVEC(NVEC)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sts_flat(sts_flat),
    .sts_we(sts_we), .reg_rdata(reg_rdata));
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int AW = 32,
  parameter int SWD = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [AW-1:0]  in_addr,
  input logic           reg_wr,
  input logic [1:0]     sts_we,
  input logic [31:0]    reg_wdata,
  input logic           cap_valid,
  input logic [SWD-1:0] sts_flat,
  input logic           irq,
  input logic           dram_valid,
  input logic [AW-1:0]  dram_addr,
  input logic           acc_err,
  input logic           win_rvalid,
  input logic           bad_vec
);
  logic clr_wr;
  assign clr_wr = reg_wr && (|sts_we) && !cap_valid;

  AST_BADVEC_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    bad_vec |-> $past(!cap_valid)); // R1
  AST_CAPTURE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> irq); // R3
  AST_PENDING_HOLDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (sts_flat != '0) |-> irq); // R3
  AST_ZERO_WRITE_NOOP: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && reg_wdata == 32'h0) |=> ($stable(sts_flat) && $stable(irq))); // R5
  AST_INIT_KEEPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && reg_wdata == 32'hFFFF_FFFF) |=> $stable(irq)); // R7
  AST_PARTIAL_CLEAR_IRQ: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && reg_wdata != 32'h0 && reg_wdata != 32'hFFFF_FFFF)
      |=> (irq == (sts_flat != '0))); // R8
  AST_DRAM_FORWARD: assert property (@(posedge clk) disable iff (rst)
    dram_valid |-> ($past(in_valid) && dram_addr == $past(in_addr) && $past(!cap_valid))); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_err, dram_valid, win_rvalid, bad_vec})); // R11
endmodule

bind msi_capture_top msi_capture_chk #(.AW(AW), .SWD(NWORDS*32)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
  .reg_wr(reg_wr), .sts_we(sts_we), .reg_wdata(reg_wdata),
  .cap_valid(cap_valid), .sts_flat(sts_flat), .irq(irq),
  .dram_valid(dram_valid), .dram_addr(dram_addr), .acc_err(acc_err),
  .win_rvalid(win_rvalid), .bad_vec(bad_vec));

// File: tb/sim_msi_capture_top.sv
`timescale 1ns/1ps
module sim_msi_capture_top;
  localparam logic [31:0] WIN = 32'h1E77_005C;
  localparam logic [7:0] A_EN0 = 8'hE0, A_EN1 = 8'hE4, A_ST0 = 8'hE8, A_ST1 = 8'hEC;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_write = 0;
  logic [31:0] in_addr = 0, in_data = 0;
  logic [3:0] in_be = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic dram_valid, dram_write, win_rvalid, acc_err, bad_vec, irq;
  logic [31:0] dram_addr, dram_wdata, win_rdata, reg_rdata;
  logic [3:0] dram_be;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  msi_capture_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_write(in_write),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
    .dram_valid(dram_valid), .dram_write(dram_write), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_be(dram_be), .win_rvalid(win_rvalid),
    .win_rdata(win_rdata), .acc_err(acc_err), .bad_vec(bad_vec),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic inb(logic wr, logic [31:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    in_valid = 1; in_write = wr; in_addr = a; in_data = d; in_be = be;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic rwr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rrd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 irq", {31'b0, irq}, 0);
    chk("R12 flags", {28'b0, acc_err, bad_vec, dram_valid, win_rvalid}, 0);
    rrd(A_EN0, rv); chk("R12 en0", rv, 0);
    rrd(A_EN1, rv); chk("R12 en1", rv, 0);
    rrd(A_ST0, rv); chk("R12 sts0", rv, 0);
    rrd(A_ST1, rv); chk("R12 sts1", rv, 0);

    // R2 R3 R8 sweep of every vector, enables left at zero (R4: no gating)
    for (int v = 0; v < 64; v++) begin
      logic [31:0] bitv;
      bitv = 32'h1 << (v % 32);
      inb(1, WIN, v, 4'hF);
      chk("R3 irq after capture", {31'b0, irq}, 1);
      rrd(v < 32 ? A_ST0 : A_ST1, rv); chk("R2 own word", rv, bitv);
      rrd(v < 32 ? A_ST1 : A_ST0, rv); chk("R2 other word", rv, 0);
      rwr(v < 32 ? A_ST0 : A_ST1, bitv);
      chk("R8 irq drop", {31'b0, irq}, 0);
      rrd(v < 32 ? A_ST0 : A_ST1, rv); chk("R6 cleared", rv, 0);
    end

    // R1 illegal vectors
    for (int v = 64; v < 72; v++) begin
      inb(1, WIN, v, 4'hF);
      chk("R1 bad_vec", {31'b0, bad_vec}, 1);
      chk("R1 irq", {31'b0, irq}, 0);
    end
    inb(1, WIN, 32'hFFFF_FFFF, 4'hF);
    chk("R1 bad_vec max", {31'b0, bad_vec}, 1);
    rrd(A_ST0, rv); chk("R1 sts0", rv, 0);
    rrd(A_ST1, rv); chk("R1 sts1", rv, 0);

    // R4 enable storage and unmapped offsets
    rwr(A_EN0, 32'hA5A5_0F0F); rwr(A_EN1, 32'h1234_5678);
    rwr(8'hF0, 32'hDEAD_BEEF); rwr(8'h00, 32'h1);
    rrd(A_EN0, rv); chk("R4 en0", rv, 32'hA5A5_0F0F);
    rrd(A_EN1, rv); chk("R4 en1", rv, 32'h1234_5678);
    rrd(8'hF0, rv); chk("R4 unmapped", rv, 0);
    rrd(A_ST0, rv); chk("R4 sts0 untouched", rv, 0);
    chk("R4 irq untouched", {31'b0, irq}, 0);

    // R5 zero write
    inb(1, WIN, 3, 4'hF);
    rwr(A_ST0, 0);
    rrd(A_ST0, rv); chk("R5 sts0 kept", rv, 32'h8);
    chk("R5 irq kept", {31'b0, irq}, 1);

    // R7 all-ones initialisation, then R8 partial clear on empty words
    rwr(A_ST0, 32'hFFFF_FFFF);
    rrd(A_ST0, rv); chk("R7 sts0 cleared", rv, 0);
    chk("R7 irq kept", {31'b0, irq}, 1);
    rwr(A_ST1, 32'h1);
    chk("R8 irq drop on empty", {31'b0, irq}, 0);

    // R8 one word still pending
    inb(1, WIN, 1, 4'hF); inb(1, WIN, 40, 4'hF);
    rwr(A_ST0, 32'h2);
    chk("R8 irq held", {31'b0, irq}, 1);
    rwr(A_ST1, 32'h100);
    chk("R8 irq dropped", {31'b0, irq}, 0);

    // R6 capture and clear in the same cycle
    inb(1, WIN, 5, 4'hF); inb(1, WIN, 6, 4'hF);
    @(negedge clk);
    in_valid = 1; in_write = 1; in_addr = WIN; in_data = 5; in_be = 4'hF;
    reg_wr = 1; reg_addr = A_ST0; reg_wdata = 32'h60;
    @(negedge clk);
    in_valid = 0; reg_wr = 0;
    chk("R6 irq on collision", {31'b0, irq}, 1);
    rrd(A_ST0, rv); chk("R6 set wins", rv, 32'h20);
    rwr(A_ST0, 32'h20);
    chk("R6 irq after final clear", {31'b0, irq}, 0);

    // R9 partial write and window read
    inb(1, WIN, 2, 4'h3);
    chk("R9 partial acc_err", {31'b0, acc_err}, 1);
    chk("R9 partial irq", {31'b0, irq}, 0);
    inb(0, WIN, 0, 4'hF);
    chk("R9 read ack", {31'b0, win_rvalid}, 1);
    chk("R9 read data", win_rdata, 0);
    chk("R9 read no err", {31'b0, acc_err}, 0);
    rrd(A_ST0, rv); chk("R9 sts0", rv, 0);

    // R10 DRAM forwarding
    inb(1, 32'h8000_0010, 32'h0000_0007, 4'h5);
    chk("R10 valid", {31'b0, dram_valid}, 1);
    chk("R10 addr", dram_addr, 32'h8000_0010);
    chk("R10 data", dram_wdata, 7);
    chk("R10 be/wr", {27'b0, dram_write, dram_be}, 5'h15);
    chk("R10 irq", {31'b0, irq}, 0);
    inb(0, 32'h8FFF_FFFC, 0, 4'hF);
    chk("R10 top of range", {31'b0, dram_valid}, 1);
    chk("R10 read flag", {31'b0, dram_write}, 0);
    rrd(A_ST0, rv); chk("R10 sts0", rv, 0);

    // R11 misses
    inb(1, 32'h9000_0000, 1, 4'hF);
    chk("R11 above range", {30'b0, acc_err, dram_valid}, 2);
    inb(1, 32'h7FFF_FFFC, 1, 4'hF);
    chk("R11 below range", {30'b0, acc_err, dram_valid}, 2);
    inb(1, WIN + 4, 1, 4'hF);
    chk("R11 next to window", {30'b0, acc_err, irq}, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule